// File: doc/BRIEF.md
# Display Identification Fetch and Checksum Sequencer

This block reads a display's identification data through a byte-wide side-channel master. It then answers the sink's test request for that data. A single start pulse runs the whole sequence. The sequencer first reads one byte that says whether an extension block follows. It then reads the 128-byte base block one byte per transaction. If the extension count is nonzero, it reads a second 128-byte block. The modulo-256 sum of each block is checked separately.

Once the data is valid, the sequencer reads the sink's test-request byte from the link-configuration register space. If the sink asks for it, the sequencer writes back the checksum byte of the last block it fetched, followed by a response flag. Every fetched byte is stored in a 256-byte buffer. A combinational read port exposes the buffer to the surrounding display logic.

The run ends with a one-cycle done pulse and a two-bit result code. Code 0 means success, 1 means a block failed its checksum, and 2 means a transaction came back with an error.

Top module: `edid_fetch_seq`

## Requirements
- R1: A start pulse while idle begins a run whose first transaction is a one-byte read on the identification port, at offset 0x7E of device 0x50. A start pulse while busy_o is high is ignored: it causes no extra done pulse and no change to the transaction sequence.
- R2: The base block is fetched as 128 single-byte reads from device 0x50, at offsets 0x00 to 0x7F in increasing order. Each byte is stored at the buffer address equal to its offset.
- R3: A block is accepted only if the modulo-256 sum of its 128 bytes is zero. A failing block ends the run with result 1, and no link-configuration transaction is issued.
- R4: A nonzero extension byte causes one more block to be read at offsets 0x80 to 0xFF, and that block's checksum is checked on its own. A zero extension byte means no read beyond offset 0x7F.
- R5: After valid data, the sequencer reads link-configuration address 0x218. If bit 2 of the returned byte is clear, the run ends with result 0 and no writes.
- R6: If bit 2 of byte 0x218 is set, the sequencer writes to address 0x261 the byte at buffer address 127 (no extension) or 255 (extension present). It then writes 0x04 to address 0x260, and the run ends with result 0.
- R7: An acknowledge that carries the error flag, on either port, ends the run with result 2. No further request follows.
- R8: done_o is a one-cycle pulse in the cycle after the clock edge that accepted the final acknowledge. status_o holds the result code (0 ok, 1 bad checksum, 2 transfer error) from that pulse until the next one.
- R9: The buffer reads as all zeros after reset. A completed run's data stays readable until the next start.
- R10: At most one of the two request outputs is high at a time. A request, together with its address and data, stays stable until it is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle end-of-run pulse |
| status_o | output | 2 | Result code: 0 ok, 1 bad checksum, 2 transfer error |
| ddc_req_o | output | 1 | Identification byte-read request |
| ddc_dev_o | output | 7 | Target device address (0x50) |
| ddc_off_o | output | 8 | Byte offset to read |
| ddc_ack_i | input | 1 | Identification read acknowledge |
| ddc_rdata_i | input | 8 | Byte returned with the acknowledge |
| ddc_err_i | input | 1 | Transfer failed, valid with the acknowledge |
| cfg_req_o | output | 1 | Link-configuration access request |
| cfg_we_o | output | 1 | 1 for write, 0 for read |
| cfg_addr_o | output | 20 | Link-configuration address |
| cfg_wdata_o | output | 8 | Write data |
| cfg_ack_i | input | 1 | Link-configuration acknowledge |
| cfg_rdata_i | input | 8 | Read data, valid with the acknowledge |
| cfg_err_i | input | 1 | Access failed, valid with the acknowledge |
| buf_raddr_i | input | 8 | Buffer read address |
| buf_rdata_o | output | 8 | Buffer byte at buf_raddr_i, combinational |

## Verification
A new request appears in the cycle after the edge that accepted the previous acknowledge. done_o rises exactly one cycle after the edge that took the final acknowledge. The bench models both slave ports and notes the cycle in which each acknowledge is driven. Its monitor requires the done pulse at the very next sample, with the result code expected by the scoreboard entry. Buffer contents and the transaction counts are checked only after done, and then again after an idle stretch, so they are never sampled while a run is still writing.

// File: rtl/edid_seq_pkg.sv
package edid_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_EXT,
    ST_BLK,
    ST_TREQ,
    ST_WCSUM,
    ST_WRESP
  } seq_st_e;

  localparam logic [1:0] RES_OK     = 2'd0;
  localparam logic [1:0] RES_BADSUM = 2'd1;
  localparam logic [1:0] RES_XFER   = 2'd2;

endpackage

// File: rtl/edid_buf.sv
module edid_buf #(
  parameter int DEPTH = 256,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr_a,
  output logic [7:0]    rdata_a,
  input  logic [AW-1:0] raddr_b,
  output logic [7:0]    rdata_b
);

  logic [7:0] mem [DEPTH];

  // one register per entry, each with its own write enable
  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    logic ent_en;
    assign ent_en = we && (waddr == AW'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mem[g] <= '0;
      end else if (ent_en) begin
        mem[g] <= wdata;
      end
    end
  end

  assign rdata_a = mem[raddr_a];
  assign rdata_b = mem[raddr_b];

endmodule

// File: rtl/edid_sum.sv
module edid_sum (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       en,
  input  logic [7:0] din,
  output logic [7:0] sum_nxt_o
);

  logic [7:0] sum_q;
  logic [7:0] sum_d;
  logic       sum_en;

  assign sum_nxt_o = sum_q + din;
  assign sum_en    = clr || en;

  always_comb begin
    if (clr) sum_d = '0;
    else     sum_d = sum_nxt_o;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sum_q <= '0;
    end else if (sum_en) begin
      sum_q <= sum_d;
    end
  end

endmodule

// File: rtl/edid_ctrl.sv
module edid_ctrl
  import edid_seq_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR   = 7'h50,
  parameter int         BLK_BYTES  = 128,
  parameter int         CFG_AW     = 20,
  parameter int         REQ_BIT    = 2,
  parameter logic [CFG_AW-1:0] TREQ_ADDR = 20'h218,
  parameter logic [CFG_AW-1:0] CSUM_ADDR = 20'h261,
  parameter logic [CFG_AW-1:0] RESP_ADDR = 20'h260,
  localparam int        OFF_W      = $clog2(2 * BLK_BYTES),
  localparam int        BLK_AW     = OFF_W - 1,
  parameter logic [OFF_W-1:0] EXT_OFFSET = 8'h7E
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [1:0]        status_o,
  output logic              ddc_req_o,
  output logic [6:0]        ddc_dev_o,
  output logic [OFF_W-1:0]  ddc_off_o,
  input  logic              ddc_ack_i,
  input  logic [7:0]        ddc_rdata_i,
  input  logic              ddc_err_i,
  output logic              cfg_req_o,
  output logic              cfg_we_o,
  output logic [CFG_AW-1:0] cfg_addr_o,
  output logic [7:0]        cfg_wdata_o,
  input  logic              cfg_ack_i,
  input  logic [7:0]        cfg_rdata_i,
  input  logic              cfg_err_i,
  output logic              buf_we_o,
  output logic [OFF_W-1:0]  buf_waddr_o,
  output logic [7:0]        buf_wdata_o,
  output logic [OFF_W-1:0]  csum_raddr_o,
  input  logic [7:0]        csum_byte_i,
  output logic              sum_clr_o,
  output logic              sum_en_o,
  input  logic [7:0]        sum_nxt_i
);

  localparam logic [7:0] RESP_VAL = 8'(1 << REQ_BIT);

  seq_st_e          st_q, st_d;
  logic [OFF_W-1:0] idx_q, idx_d;
  logic             ext_q, ext_d;
  logic             done_q, done_d;
  logic [1:0]       res_q, res_d;
  logic             fin;
  logic [1:0]       fin_code;
  logic             ddc_take, cfg_take;
  logic             blk_last;
  logic             seq_en;

  assign ddc_take = ddc_req_o && ddc_ack_i;
  assign cfg_take = cfg_req_o && cfg_ack_i;
  assign blk_last = (idx_q[BLK_AW-1:0] == {BLK_AW{1'b1}});

  // next-state process
  always_comb begin
    st_d      = st_q;
    idx_d     = idx_q;
    ext_d     = ext_q;
    res_d     = res_q;
    done_d    = 1'b0;
    fin       = 1'b0;
    fin_code  = RES_OK;
    sum_clr_o = 1'b0;
    sum_en_o  = 1'b0;
    buf_we_o  = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (start_i) begin
          st_d      = ST_EXT;
          sum_clr_o = 1'b1;
        end
      end
      ST_EXT: begin
        if (ddc_take) begin
          if (ddc_err_i) begin
            fin = 1'b1; fin_code = RES_XFER;
          end else begin
            ext_d = |ddc_rdata_i;
            idx_d = '0;
            st_d  = ST_BLK;
          end
        end
      end
      ST_BLK: begin
        if (ddc_take) begin
          if (ddc_err_i) begin
            fin = 1'b1; fin_code = RES_XFER;
          end else begin
            buf_we_o = 1'b1;
            sum_en_o = 1'b1;
            idx_d    = idx_q + 1'b1;
            if (blk_last) begin
              sum_clr_o = 1'b1;
              if (sum_nxt_i != 8'h00) begin
                fin = 1'b1; fin_code = RES_BADSUM;
              end else if (ext_q && !idx_q[BLK_AW]) begin
                st_d = ST_BLK;
              end else begin
                st_d = ST_TREQ;
              end
            end
          end
        end
      end
      ST_TREQ: begin
        if (cfg_take) begin
          if (cfg_err_i) begin
            fin = 1'b1; fin_code = RES_XFER;
          end else if (cfg_rdata_i[REQ_BIT]) begin
            st_d = ST_WCSUM;
          end else begin
            fin = 1'b1; fin_code = RES_OK;
          end
        end
      end
      ST_WCSUM: begin
        if (cfg_take) begin
          if (cfg_err_i) begin
            fin = 1'b1; fin_code = RES_XFER;
          end else begin
            st_d = ST_WRESP;
          end
        end
      end
      ST_WRESP: begin
        if (cfg_take) begin
          fin      = 1'b1;
          fin_code = cfg_err_i ? RES_XFER : RES_OK;
        end
      end
      default: st_d = ST_IDLE;
    endcase
    if (fin) begin
      st_d   = ST_IDLE;
      done_d = 1'b1;
      res_d  = fin_code;
    end
  end

  // clock enable: state registers move only while a run is active or starting
  assign seq_en = (st_q != ST_IDLE) || start_i || done_q;

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      idx_q  <= '0;
      ext_q  <= 1'b0;
      done_q <= 1'b0;
      res_q  <= RES_OK;
    end else if (seq_en) begin
      st_q   <= st_d;
      idx_q  <= idx_d;
      ext_q  <= ext_d;
      done_q <= done_d;
      res_q  <= res_d;
    end
  end

  // output decode
  assign busy_o       = (st_q != ST_IDLE);
  assign done_o       = done_q;
  assign status_o     = res_q;
  assign ddc_req_o    = (st_q == ST_EXT) || (st_q == ST_BLK);
  assign ddc_dev_o    = DEV_ADDR;
  assign ddc_off_o    = (st_q == ST_EXT) ? EXT_OFFSET : idx_q;
  assign cfg_req_o    = (st_q == ST_TREQ) || (st_q == ST_WCSUM) || (st_q == ST_WRESP);
  assign cfg_we_o     = (st_q == ST_WCSUM) || (st_q == ST_WRESP);
  assign buf_waddr_o  = idx_q;
  assign buf_wdata_o  = ddc_rdata_i;
  assign csum_raddr_o = ext_q ? OFF_W'(2 * BLK_BYTES - 1) : OFF_W'(BLK_BYTES - 1);

  always_comb begin
    unique case (st_q)
      ST_WCSUM: begin cfg_addr_o = CSUM_ADDR; cfg_wdata_o = csum_byte_i; end
      ST_WRESP: begin cfg_addr_o = RESP_ADDR; cfg_wdata_o = RESP_VAL;    end
      default:  begin cfg_addr_o = TREQ_ADDR; cfg_wdata_o = 8'h00;       end
    endcase
  end

endmodule

// File: rtl/edid_fetch_seq.sv
module edid_fetch_seq #(
  parameter logic [6:0] DEV_ADDR  = 7'h50,
  parameter int         BLK_BYTES = 128,
  parameter int         CFG_AW    = 20,
  parameter int         REQ_BIT   = 2,
  parameter logic [CFG_AW-1:0] TREQ_ADDR = 20'h218,
  parameter logic [CFG_AW-1:0] CSUM_ADDR = 20'h261,
  parameter logic [CFG_AW-1:0] RESP_ADDR = 20'h260,
  localparam int        BUF_DEPTH = 2 * BLK_BYTES,
  localparam int        OFF_W     = $clog2(BUF_DEPTH),
  parameter logic [OFF_W-1:0] EXT_OFFSET = 8'h7E
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [1:0]        status_o,
  output logic              ddc_req_o,
  output logic [6:0]        ddc_dev_o,
  output logic [OFF_W-1:0]  ddc_off_o,
  input  logic              ddc_ack_i,
  input  logic [7:0]        ddc_rdata_i,
  input  logic              ddc_err_i,
  output logic              cfg_req_o,
  output logic              cfg_we_o,
  output logic [CFG_AW-1:0] cfg_addr_o,
  output logic [7:0]        cfg_wdata_o,
  input  logic              cfg_ack_i,
  input  logic [7:0]        cfg_rdata_i,
  input  logic              cfg_err_i,
  input  logic [OFF_W-1:0]  buf_raddr_i,
  output logic [7:0]        buf_rdata_o
);

  logic             buf_we;
  logic [OFF_W-1:0] buf_waddr;
  logic [7:0]       buf_wdata;
  logic [OFF_W-1:0] csum_raddr;
  logic [7:0]       csum_byte;
  logic             sum_clr;
  logic             sum_en;
  logic [7:0]       sum_nxt;

  edid_ctrl #(
    .DEV_ADDR   (DEV_ADDR),
    .BLK_BYTES  (BLK_BYTES),
    .CFG_AW     (CFG_AW),
    .REQ_BIT    (REQ_BIT),
    .TREQ_ADDR  (TREQ_ADDR),
    .CSUM_ADDR  (CSUM_ADDR),
    .RESP_ADDR  (RESP_ADDR),
    .EXT_OFFSET (EXT_OFFSET)
  ) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .busy_o       (busy_o),
    .done_o       (done_o),
    .status_o     (status_o),
    .ddc_req_o    (ddc_req_o),
    .ddc_dev_o    (ddc_dev_o),
    .ddc_off_o    (ddc_off_o),
    .ddc_ack_i    (ddc_ack_i),
    .ddc_rdata_i  (ddc_rdata_i),
    .ddc_err_i    (ddc_err_i),
    .cfg_req_o    (cfg_req_o),
    .cfg_we_o     (cfg_we_o),
    .cfg_addr_o   (cfg_addr_o),
    .cfg_wdata_o  (cfg_wdata_o),
    .cfg_ack_i    (cfg_ack_i),
    .cfg_rdata_i  (cfg_rdata_i),
    .cfg_err_i    (cfg_err_i),
    .buf_we_o     (buf_we),
    .buf_waddr_o  (buf_waddr),
    .buf_wdata_o  (buf_wdata),
    .csum_raddr_o (csum_raddr),
    .csum_byte_i  (csum_byte),
    .sum_clr_o    (sum_clr),
    .sum_en_o     (sum_en),
    .sum_nxt_i    (sum_nxt)
  );

  edid_sum u_sum (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (sum_clr),
    .en        (sum_en),
    .din       (ddc_rdata_i),
    .sum_nxt_o (sum_nxt)
  );

  edid_buf #(
    .DEPTH (BUF_DEPTH),
    .AW    (OFF_W)
  ) u_buf (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (buf_we),
    .waddr   (buf_waddr),
    .wdata   (buf_wdata),
    .raddr_a (buf_raddr_i),
    .rdata_a (buf_rdata_o),
    .raddr_b (csum_raddr),
    .rdata_b (csum_byte)
  );

endmodule

// File: rtl/edid_fetch_chk.sv
module edid_fetch_chk #(
  parameter int OFF_W  = 8,
  parameter int CFG_AW = 20,
  parameter logic [OFF_W-1:0] EXT_OFFSET = 8'h7E,
  parameter logic [CFG_AW-1:0] TREQ_ADDR = 20'h218,
  parameter logic [CFG_AW-1:0] RESP_ADDR = 20'h260
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy_o,
  input logic              done_o,
  input logic [1:0]        status_o,
  input logic              ddc_req_o,
  input logic [OFF_W-1:0]  ddc_off_o,
  input logic              ddc_ack_i,
  input logic              ddc_err_i,
  input logic              cfg_req_o,
  input logic              cfg_we_o,
  input logic [CFG_AW-1:0] cfg_addr_o,
  input logic [7:0]        cfg_wdata_o,
  input logic              cfg_ack_i,
  input logic              cfg_err_i
);

  // R10: never two outstanding requests
  a_r10_one_port: assert property (@(posedge clk) disable iff (!rst_n)
    !(ddc_req_o && cfg_req_o));

  // R10: identification request held with a stable offset until acknowledged
  a_r10_ddc_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (ddc_req_o && !ddc_ack_i) |=> (ddc_req_o && $stable(ddc_off_o)));

  // R10: configuration request held with stable fields until acknowledged
  a_r10_cfg_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_req_o && !cfg_ack_i) |=> (cfg_req_o && $stable(cfg_addr_o)
                                   && $stable(cfg_we_o) && $stable(cfg_wdata_o)));

  // R1: a run opens with the extension-count read
  a_r1_first_read: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> (ddc_req_o && ddc_off_o == EXT_OFFSET));

  // R8: done lasts one cycle
  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R8: done follows an accepted acknowledge
  a_r8_done_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_o) |-> $past((ddc_req_o && ddc_ack_i) || (cfg_req_o && cfg_ack_i)));

  // R7: a failed transfer ends the run with code 2
  a_r7_ddc_err_end: assert property (@(posedge clk) disable iff (!rst_n)
    (ddc_req_o && ddc_ack_i && ddc_err_i) |=> (done_o && status_o == 2'd2 && !ddc_req_o));

  a_r7_cfg_err_end: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_req_o && cfg_ack_i && cfg_err_i) |=> (done_o && status_o == 2'd2 && !cfg_req_o));

  // R5: the only configuration read is the test-request byte
  a_r5_read_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_req_o && !cfg_we_o) |-> (cfg_addr_o == TREQ_ADDR));

  // R6: response write carries the request flag
  a_r6_resp_val: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_req_o && cfg_we_o && cfg_addr_o == RESP_ADDR) |-> (cfg_wdata_o == 8'h04));

endmodule

bind edid_fetch_seq edid_fetch_chk #(
  .OFF_W      (OFF_W),
  .CFG_AW     (CFG_AW),
  .EXT_OFFSET (EXT_OFFSET),
  .TREQ_ADDR  (TREQ_ADDR),
  .RESP_ADDR  (RESP_ADDR)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .status_o    (status_o),
  .ddc_req_o   (ddc_req_o),
  .ddc_off_o   (ddc_off_o),
  .ddc_ack_i   (ddc_ack_i),
  .ddc_err_i   (ddc_err_i),
  .cfg_req_o   (cfg_req_o),
  .cfg_we_o    (cfg_we_o),
  .cfg_addr_o  (cfg_addr_o),
  .cfg_wdata_o (cfg_wdata_o),
  .cfg_ack_i   (cfg_ack_i),
  .cfg_err_i   (cfg_err_i)
);

// File: tb/sim_edid_fetch_seq.sv
module sim_edid_fetch_seq;

  localparam int CLK_PERIOD = 10;
  localparam int BLK = 128;

  logic        clk;
  logic        rst_n;
  logic        start_i;
  logic        busy_o, done_o;
  logic [1:0]  status_o;
  logic        ddc_req_o;
  logic [6:0]  ddc_dev_o;
  logic [7:0]  ddc_off_o;
  logic        ddc_ack_i, ddc_err_i;
  logic [7:0]  ddc_rdata_i;
  logic        cfg_req_o, cfg_we_o;
  logic [19:0] cfg_addr_o;
  logic [7:0]  cfg_wdata_o;
  logic        cfg_ack_i, cfg_err_i;
  logic [7:0]  cfg_rdata_i;
  logic [7:0]  buf_raddr_i;
  logic [7:0]  buf_rdata_o;

  edid_fetch_seq u0 (.*);

  typedef struct { logic [1:0] code; string tag; } exp_t;
  exp_t exp_q[$];

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  int last_ack_cyc = -10;
  int done_cnt = 0;

  logic [7:0] img [256];
  int   lat = 0;
  int   ddc_fail = -1;
  bit   cfg_fail = 0;
  logic [7:0] treq_val = 8'h00;
  int   ddc_n = 0;
  bit   ddc_order_bad = 0;
  int   cfg_n = 0;
  int   wr_n = 0;
  logic [19:0] wr_addr [2];
  logic [7:0]  wr_data [2];

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic finish_test();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  // identification slave model
  always begin
    @(negedge clk);
    ddc_ack_i = 1'b0;
    ddc_err_i = 1'b0;
    if (ddc_req_o) begin
      if (ddc_dev_o != 7'h50) ddc_order_bad = 1;
      if (ddc_n == 0 && ddc_off_o != 8'h7E) ddc_order_bad = 1;
      if (ddc_n > 0 && ddc_off_o != 8'(ddc_n - 1)) ddc_order_bad = 1;
      repeat (lat) @(negedge clk);
      ddc_rdata_i  = img[ddc_off_o];
      ddc_err_i    = (ddc_n == ddc_fail);
      ddc_ack_i    = 1'b1;
      last_ack_cyc = cyc;
      ddc_n++;
    end
  end

  // link-configuration slave model
  always begin
    @(negedge clk);
    cfg_ack_i = 1'b0;
    cfg_err_i = 1'b0;
    if (cfg_req_o) begin
      repeat (lat) @(negedge clk);
      if (cfg_we_o) begin
        if (wr_n < 2) begin
          wr_addr[wr_n] = cfg_addr_o;
          wr_data[wr_n] = cfg_wdata_o;
        end
        wr_n++;
      end else begin
        cfg_rdata_i = treq_val;
        cfg_err_i   = cfg_fail;
      end
      cfg_ack_i    = 1'b1;
      last_ack_cyc = cyc;
      cfg_n++;
    end
  end

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && done_o) begin
      done_cnt++;
      check(cyc == last_ack_cyc + 1, "R8", "done latency after last ack", cyc, last_ack_cyc + 1);
      if (exp_q.size() == 0) begin
        check(1'b0, "R1", "unexpected done pulse", 1, 0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        check(status_o == e.code, e.tag, "result code", status_o, e.code);
      end
    end
  end

  task automatic build_img(input int ext, input bit bad0, input bit bad1, input int seed);
    logic [7:0] s;
    for (int i = 0; i < 256; i++) img[i] = 8'(i * 37 + seed);
    img[126] = 8'(ext);
    img[127] = 8'h00;
    s = 8'h00;
    for (int i = 0; i < BLK; i++) s = s + img[i];
    img[127] = 8'(-s) + (bad0 ? 8'h01 : 8'h00);
    img[255] = 8'h00;
    s = 8'h00;
    for (int i = BLK; i < 2 * BLK; i++) s = s + img[i];
    img[255] = 8'(-s) + (bad1 ? 8'h01 : 8'h00);
  endtask

  task automatic buf_match(input int lo, input int hi, input string req, input string what);
    int bad = 0;
    int first = -1;
    for (int a = lo; a <= hi; a++) begin
      buf_raddr_i = 8'(a);
      #1;
      if (buf_rdata_o !== img[a]) begin
        bad++;
        if (first < 0) first = a;
      end
    end
    check(bad == 0, req, what, bad, 0);
  endtask

  // driver: builds the expectation, pushes it, runs the sequence, checks side effects
  task automatic run_case(input int ext, input bit bad0, input bit bad1,
                          input logic [7:0] treq, input int dfail, input bit cfail,
                          input int l, input bit restart, input string tag);
    int nd_full, nd, ncfg, nwr, d0, wd;
    logic [1:0] code;
    exp_t e;
    build_img(ext, bad0, bad1, ext * 11 + l * 5 + 3);
    lat = l; ddc_fail = dfail; cfg_fail = cfail; treq_val = treq;
    ddc_n = 0; ddc_order_bad = 0; cfg_n = 0; wr_n = 0;
    nd_full = 1 + BLK + ((ext != 0 && !bad0) ? BLK : 0);
    nwr = 0;
    if (dfail >= 0 && dfail < nd_full) begin
      code = 2'd2; nd = dfail + 1; ncfg = 0;
    end else begin
      nd = nd_full;
      if (bad0 || (ext != 0 && bad1)) begin code = 2'd1; ncfg = 0; end
      else if (cfail)                 begin code = 2'd2; ncfg = 1; end
      else if (treq[2])               begin code = 2'd0; ncfg = 3; nwr = 2; end
      else                            begin code = 2'd0; ncfg = 1; end
    end
    e.code = code; e.tag = tag;
    exp_q.push_back(e);
    d0 = done_cnt;
    @(negedge clk); start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    if (restart) begin
      repeat (20) @(negedge clk);
      start_i = 1'b1;
      @(negedge clk); start_i = 1'b0;
    end
    wd = 0;
    while (done_cnt == d0 && wd < 20000) begin @(negedge clk); wd++; end
    if (done_cnt == d0) begin
      check(1'b0, tag, "watchdog, no done", 0, 1);
      finish_test();
    end
    repeat (30) @(negedge clk);
    check(done_cnt == d0 + 1, "R1", "done pulses per start", done_cnt - d0, 1);
    check(!busy_o, "R8", "idle after done", busy_o, 0);
    check(ddc_n == nd && !ddc_order_bad, "R2", "identification reads count/order", ddc_n, nd);
    check(cfg_n == ncfg, (code == 2'd1) ? "R3" : "R5", "configuration transactions", cfg_n, ncfg);
    check(wr_n == nwr, "R6", "configuration writes", wr_n, nwr);
    if (nwr == 2) begin
      logic [7:0] cs;
      cs = (ext != 0) ? img[255] : img[127];
      check(wr_addr[0] == 20'h261 && wr_data[0] == cs, "R6", "checksum write", wr_data[0], cs);
      check(wr_addr[1] == 20'h260 && wr_data[1] == 8'h04, "R6", "response write", wr_data[1], 8'h04);
    end
    if (dfail < 0) begin
      buf_match(0, BLK - 1, "R2", "base block in buffer");
      if (ext != 0 && !bad0) buf_match(BLK, 2 * BLK - 1, "R4", "extension block in buffer");
      repeat (40) @(negedge clk);
      buf_match(0, BLK - 1, "R9", "buffer holds after done");
    end
  endtask

  initial begin
    start_i = 1'b0; buf_raddr_i = 8'h00;
    ddc_ack_i = 1'b0; ddc_err_i = 1'b0; ddc_rdata_i = 8'h00;
    cfg_ack_i = 1'b0; cfg_err_i = 1'b0; cfg_rdata_i = 8'h00;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9: cleared buffer, idle outputs after reset
    begin
      int nz = 0;
      for (int a = 0; a < 256; a += 17) begin
        buf_raddr_i = 8'(a); #1;
        if (buf_rdata_o !== 8'h00) nz++;
      end
      check(nz == 0, "R9", "buffer zero after reset", nz, 0);
    end
    check(!busy_o && !done_o && !ddc_req_o && !cfg_req_o, "R8", "idle after reset",
          {busy_o, done_o, ddc_req_o, cfg_req_o}, 0);

    //       ext bad0 bad1 treq  dfail cfail lat restart tag
    run_case(0, 0, 0, 8'h00, -1, 0, 0, 0, "R5");
    run_case(0, 0, 0, 8'h04, -1, 0, 2, 0, "R6");
    run_case(1, 0, 0, 8'h06, -1, 0, 1, 0, "R4");
    run_case(1, 0, 0, 8'hFB, -1, 0, 0, 0, "R5");
    run_case(0, 1, 0, 8'h04, -1, 0, 0, 0, "R3");
    run_case(2, 0, 1, 8'h04, -1, 0, 1, 0, "R3");
    run_case(1, 1, 0, 8'h04, -1, 0, 0, 0, "R3");
    run_case(0, 0, 0, 8'h04,  0, 0, 0, 0, "R7");
    run_case(1, 0, 0, 8'h04, 50, 0, 1, 0, "R7");
    run_case(1, 0, 0, 8'h04, 200, 0, 0, 0, "R7");
    run_case(0, 0, 0, 8'h04, -1, 1, 0, 0, "R7");
    run_case(1, 0, 0, 8'h04, -1, 0, 0, 1, "R1");
    finish_test();
  end

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "R8", "global watchdog expired", 0, 1);
    finish_test();
  end

endmodule